// File: doc/BRIEF.md
# Multi-phase ring-oscillator edge counter quantizer

This block is the digital back end of an oscillator-based noise-shaping converter. A ring oscillator whose rate follows the analog input offers several evenly spaced taps, and each tap is an asynchronous square wave. On every sample-clock edge the block works out how many of those taps have changed level since the previous edge. That count is the output code for the sample period. Because the count of level changes is the first difference of the oscillator's running phase, the quantization error is shaped to first order without any feedback inside the block. Using more taps gives a finer code.

Two ways of forming the code are offered. In the direct-count mode, every tap passes through a synchronizer and then an edge detector. The per-tap edge flags are summed and the sum is registered as the code. In the running-phase mode, the sum is added into a free-running accumulator that wraps modulo a power of two. The code is the wrapped difference between two successive accumulator values, so it comes out one sample later than in the direct-count mode. Both paths run on every edge, and a registered mode select chooses which one drives the output.

A small sequencer decides when the output is valid. It has three states:
- `ST_CLEAR` is the state held in reset. On the first edge after reset it moves to `ST_FILL`.
- `ST_FILL` counts edges while the pipeline fills. It moves to `ST_RUN` on the fifth edge after reset.
- `ST_RUN` is kept until the next reset.

Outside `ST_RUN` the code is forced to zero and the valid flag is low.

Top module: `osc_phase_digitizer`

## Requirements
- R1: While reset is asserted and until the fifth clock edge after reset is released, `code_valid` is 0 and `code_out` is 0.
- R2: From the fifth clock edge after reset release onward, `code_valid` is 1 on every cycle until the next reset.
- R3: In direct-count mode (`mode_sel` = 0 at edge k), the valid code after edge k is the number of bit positions in which the `phase_in` sample taken at edge k-2 differs from the sample taken at edge k-3.
- R4: In running-phase mode (`mode_sel` = 1 at edge k), the valid code after edge k is the number of bit positions in which the sample at edge k-3 differs from the sample at edge k-4.
- R5: The running-phase code stays correct across any number of wraps of the ACC_W-bit accumulator. The difference is taken modulo 2^ACC_W, and ACC_W exceeds the code width.
- R6: The mode applied at edge k selects the code shown after edge k. Switching modes needs no refill and never drops `code_valid`.
- R7: If no tap changes, the code is 0. If every tap toggles on every edge, the code is NUM_PH. The code never exceeds NUM_PH.
- R8: Every tap has the same latency from input to code, so a change on any single tap adds exactly 1 to the code in the same sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock at the converter rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_in | input | NUM_PH | Asynchronous ring-oscillator taps |
| mode_sel | input | 1 | 0 selects the direct-count code, 1 selects the running-phase code |
| code_out | output | $clog2(NUM_PH+1) | Number of tap transitions in the sample period |
| code_valid | output | 1 | High once the pipeline has filled after reset |

## Verification
The bench keeps a behavioural model: a queue of the tap samples and modes applied at each edge. It compares both outputs after every edge. The stimulus sets are:
- Held-constant taps, which must give zero.
- Every tap toggling on every edge, which gives the largest code and wraps the accumulator many times.
- A single tap walking across the bus, which exposes any tap whose latency differs from the others.
- Random tap patterns under both modes and with the mode alternating, which separate the two latencies.

A reset in the middle of a run confirms that the output stays forced to zero through the refill.

// File: rtl/odig_pkg.sv
package odig_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_FILL  = 2'd1,
        ST_RUN   = 2'd2
    } fill_state_t;

    typedef enum logic {
        MODE_DIRECT  = 1'b0,
        MODE_RUNNING = 1'b1
    } quant_mode_t;

    // number of set bits in a vector of up to 64 bits
    function automatic int unsigned ones_in(input logic [63:0] vec, input int unsigned len);
        int unsigned total;
        total = 0;
        for (int unsigned i = 0; i < 64; i++) begin
            if (i < len && vec[i]) total++;
        end
        return total;
    endfunction

endpackage

// File: rtl/odig_sync.sv
module odig_sync #(
    parameter int NUM_PH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PH-1:0] taps_async,
    output logic [NUM_PH-1:0] taps_sync
);

    // identical two-stage synchronizer on every tap keeps latency uniform
    for (genvar g = 0; g < NUM_PH; g++) begin : g_tap
        logic meta_q;
        logic stable_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= taps_async[g];
                stable_q <= meta_q;
            end
        end
        assign taps_sync[g] = stable_q;
    end

endmodule

// File: rtl/odig_edge.sv
module odig_edge #(
    parameter int NUM_PH = 5,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PH-1:0] taps_sync,
    output logic [CODE_W-1:0] edge_sum,
    output logic [CODE_W-1:0] direct_code
);
    import odig_pkg::*;

    logic [NUM_PH-1:0] taps_prev_q;
    logic [NUM_PH-1:0] toggled;
    logic [63:0]       toggled_wide;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taps_prev_q <= '0;
        else        taps_prev_q <= taps_sync;
    end

    assign toggled      = taps_sync ^ taps_prev_q;
    assign toggled_wide = 64'(toggled);
    assign edge_sum     = CODE_W'(ones_in(toggled_wide, NUM_PH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) direct_code <= '0;
        else        direct_code <= edge_sum;
    end

endmodule

// File: rtl/odig_phase_acc.sv
module odig_phase_acc #(
    parameter int CODE_W = 3,
    parameter int ACC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] edge_sum,
    output logic [CODE_W-1:0] running_code
);

    logic [ACC_W-1:0] phase_acc_q;
    logic [ACC_W-1:0] phase_acc_d1_q;
    logic [ACC_W-1:0] phase_step;

    // free-running cumulative phase, wraps modulo 2^ACC_W
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_acc_q    <= '0;
            phase_acc_d1_q <= '0;
        end else begin
            phase_acc_q    <= phase_acc_q + ACC_W'(edge_sum);
            phase_acc_d1_q <= phase_acc_q;
        end
    end

    // first difference in the same modulus
    assign phase_step = phase_acc_q - phase_acc_d1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) running_code <= '0;
        else        running_code <= phase_step[CODE_W-1:0];
    end

endmodule

// File: rtl/osc_phase_digitizer.sv
module osc_phase_digitizer #(
    parameter int NUM_PH = 5,
    parameter int ACC_W  = 4,
    localparam int CODE_W = $clog2(NUM_PH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PH-1:0] phase_in,
    input  logic              mode_sel,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid
);
    import odig_pkg::*;

    localparam int FILL_EDGES = 5;
    localparam int FILL_W     = $clog2(FILL_EDGES + 1);

    logic [NUM_PH-1:0] taps_sync;
    logic [CODE_W-1:0] edge_sum;
    logic [CODE_W-1:0] direct_code;
    logic [CODE_W-1:0] running_code;
    fill_state_t       state_q, state_nx;
    logic [FILL_W-1:0] fill_cnt_q;
    quant_mode_t       mode_q;

    odig_sync #(.NUM_PH(NUM_PH)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .taps_async (phase_in),
        .taps_sync  (taps_sync)
    );

    odig_edge #(.NUM_PH(NUM_PH), .CODE_W(CODE_W)) i_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .taps_sync   (taps_sync),
        .edge_sum    (edge_sum),
        .direct_code (direct_code)
    );

    odig_phase_acc #(.CODE_W(CODE_W), .ACC_W(ACC_W)) i_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .edge_sum     (edge_sum),
        .running_code (running_code)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_nx;
    end

    // fill counter and registered mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt_q <= '0;
            mode_q     <= MODE_DIRECT;
        end else begin
            mode_q <= quant_mode_t'(mode_sel);
            if (state_q == ST_CLEAR)     fill_cnt_q <= FILL_W'(1);
            else if (state_q == ST_FILL) fill_cnt_q <= fill_cnt_q + FILL_W'(1);
        end
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_CLEAR: state_nx = ST_FILL;
            ST_FILL:  if (fill_cnt_q == FILL_W'(FILL_EDGES - 1)) state_nx = ST_RUN;
            ST_RUN:   state_nx = ST_RUN;
            default:  state_nx = ST_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        code_valid = 1'b0;
        code_out   = '0;
        unique case (state_q)
            ST_RUN: begin
                code_valid = 1'b1;
                code_out   = (mode_q == MODE_RUNNING) ? running_code : direct_code;
            end
            default: begin
                code_valid = 1'b0;
                code_out   = '0;
            end
        endcase
    end

endmodule

// File: rtl/odig_checker.sv
module odig_checker #(
    parameter int NUM_PH = 5,
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_PH-1:0] phase_in,
    input logic              mode_sel,
    input logic [CODE_W-1:0] code_out,
    input logic              code_valid
);
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(NUM_PH);

    assert_quiet_when_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |-> code_out == '0);

    assert_valid_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> code_valid);

    assert_code_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        code_out <= MAX_CODE);

    // taps unchanged over the last five edges: either mode shows zero (R3, R4)
    assert_steady_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && $past(phase_in, 1) == $past(phase_in, 2)
                    && $past(phase_in, 2) == $past(phase_in, 3)
                    && $past(phase_in, 3) == $past(phase_in, 4)
                    && $past(phase_in, 4) == $past(phase_in, 5))
        |-> code_out == '0);

    // every tap flipping on each edge: either mode shows NUM_PH (R7, R4)
    assert_full_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && $past(phase_in, 3) == ~$past(phase_in, 4)
                    && $past(phase_in, 4) == ~$past(phase_in, 5))
        |-> code_out == MAX_CODE);

    initial begin
        assert_width_margin_R5: assert (CODE_W >= 1 && NUM_PH >= 1);
    end

endmodule

bind osc_phase_digitizer odig_checker #(.NUM_PH(NUM_PH), .CODE_W(CODE_W)) i_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_in   (phase_in),
    .mode_sel   (mode_sel),
    .code_out   (code_out),
    .code_valid (code_valid)
);

// File: tb/test_osc_phase_digitizer.sv
module test_osc_phase_digitizer;

    localparam int PERIOD = 10;
    localparam int NP     = 5;
    localparam int AW     = 4;
    localparam int CW     = $clog2(NP + 1);
    localparam int FILL   = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] phase_in = '0;
    logic          mode_sel = 1'b0;
    logic [CW-1:0] code_out;
    logic          code_valid;

    int n_vec  = 0;
    int n_fail = 0;
    int k      = 0;
    logic [NP-1:0] xs[$];
    logic          ms[$];

    always #(PERIOD/2) clk = ~clk;

    osc_phase_digitizer #(.NUM_PH(NP), .ACC_W(AW)) i_osc_phase_digitizer (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_in   (phase_in),
        .mode_sel   (mode_sel),
        .code_out   (code_out),
        .code_valid (code_valid)
    );

    function automatic int ref_code(int e);
        if (e < FILL) return 0;
        if (ms[e]) return $countones(xs[e-3] ^ xs[e-4]);
        return $countones(xs[e-2] ^ xs[e-3]);
    endfunction

    task automatic compare(input string tag, input int exp_c, input logic exp_v);
        n_vec++;
        if (code_out !== CW'(exp_c) || code_valid !== exp_v) begin
            n_fail++;
            $display("FAIL %s edge %0d: code=%0d valid=%0b expected code=%0d valid=%0b",
                     tag, k, code_out, code_valid, exp_c, exp_v);
        end
    endtask

    // reset held for some edges, R1 checked during it; ends at a negedge
    task automatic do_reset(input int edges);
        rst_n = 1'b0;
        for (int i = 0; i < edges; i++) begin
            @(posedge clk);
            #(PERIOD/4);
            compare("R1", 0, 1'b0);
            @(negedge clk);
        end
        rst_n = 1'b1;
        k = 0;
        xs.delete(); ms.delete();
        xs.push_back('0); ms.push_back(1'b0);
    endtask

    task automatic step(input logic [NP-1:0] ph, input logic md, input string tag);
        phase_in = ph;
        mode_sel = md;
        @(posedge clk);
        k++;
        xs.push_back(ph);
        ms.push_back(md);
        #(PERIOD/4);
        compare(tag, ref_code(k), k >= FILL);
        @(negedge clk);
    endtask

    initial begin
        logic [NP-1:0] cur;
        @(negedge clk);
        do_reset(3);

        // R1 fill window and R2 valid rising, steady taps (R7 zero)
        cur = '1;
        for (int i = 0; i < 4; i++) step(cur, 1'b0, "R1");
        for (int i = 0; i < 6; i++) step(cur, 1'b0, "R2");

        // R7 all taps toggling, direct mode
        for (int i = 0; i < 8; i++) begin cur = ~cur; step(cur, 1'b0, "R7"); end

        // R5 all taps toggling in running mode, many accumulator wraps
        for (int i = 0; i < 40; i++) begin cur = ~cur; step(cur, 1'b1, "R5"); end

        // R8 single tap walking, both modes
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < NP; b++) begin
                cur[b] = ~cur[b];
                step(cur, 1'(m), "R8");
                step(cur, 1'(m), "R8");
                step(cur, 1'(m), "R8");
            end
        end

        // R3 random taps, direct mode
        for (int i = 0; i < 60; i++) begin cur = NP'($urandom); step(cur, 1'b0, "R3"); end
        // R4 random taps, running mode
        for (int i = 0; i < 60; i++) begin cur = NP'($urandom); step(cur, 1'b1, "R4"); end
        // R6 mode alternating every edge
        for (int i = 0; i < 60; i++) begin cur = NP'($urandom); step(cur, 1'(i % 2), "R6"); end

        // reset mid run, taps held high so edges straddle the release (R1, R2)
        cur = '1;
        phase_in = cur;
        do_reset(2);
        for (int i = 0; i < 4; i++) step(cur, 1'b1, "R1");
        for (int i = 0; i < 20; i++) begin cur = NP'($urandom); step(cur, 1'b1, "R2"); end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule